// File: doc/BRIEF.md
# Banked Clock Divider with Polarity Control

This block takes one input clock and fans it out to four banks of five outputs each. Each bank has its own rate select. The select either passes the input clock straight through or passes half of it. All halved banks take their signal from one shared toggle flop, so they stay in phase with each other.

A two-bit polarity code sets which banks are inverted. Inversion grows from the first bank upward, and the first bank is inverted for every code. One active-low input serves as both reset and output enable. While it is low, every output is disabled and the divider is cleared. High impedance is modelled as a per-output enable bit next to a data bit.

When the enable input rises, the outputs turn on at once but stay at their rest levels. They start to switch only after the release has passed through a two-flop synchroniser.

Top module: `bank_clk_div`

## Requirements
- R1: Within a bank, all five data bits always hold the same value. All twenty enable bits always hold the same value.
- R2: Select bit 0 picks the halved rate for a bank. After a release, the bank's un-inverted value is low up to the second rising clock edge. It goes high at the third rising edge and then changes on every rising edge.
- R3: Select bit 1 picks the full rate for a bank. From the second rising edge after a release, the bank's un-inverted value equals the input clock level.
- R4: Bank b is inverted when b is at most the polarity code read as an unsigned number. Bank index 0 is bank A and bit 0 of each vector belongs to bank A. Code 0 inverts only A, code 1 inverts A and B, code 2 inverts A to C, and code 3 inverts all four banks.
- R5: While the enable input is low, every enable bit is 0, with no clock edge needed.
- R6: During reset and until the synchroniser has released the divider, non-inverted banks output 0 and inverted banks output 1.
- R7: All banks on the halved rate carry the same un-inverted value at all times.
- R8: While the enable input is high, every enable bit is 1, with no clock edge needed.
- R9: Pulling the enable input low during operation at once returns all data bits to the R6 rest levels and clears the divider.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_in | input | 1 | Input clock; the divider advances on its rising edge |
| oe_n_rst | input | 1 | Active-low output enable and divider reset |
| div_sel | input | 4 | One rate select per bank: 1 for full rate, 0 for half rate |
| pol_code | input | 2 | Polarity code that sets the cumulative bank inversion |
| q_data | output | 20 | Output data; bank b occupies bits 5b to 5b+4 |
| q_oe | output | 20 | Per-output drive enable; 0 models high impedance |

## Verification
The assertions assume that the rate selects and the polarity code are static configuration. They assume these inputs change only while the enable input is low, which is also when the clocked properties are disabled. The bench keeps to this. It changes the configuration only while the block is held in reset, then releases it and samples mid-high and mid-low on each cycle. It covers all sixteen select patterns under all four polarity codes. Every run of a configuration ends with an asynchronous reset in the middle of a high phase.

// File: rtl/bank_clk_div.sv
module bank_clk_div #(
  parameter int NBANK = 4,
  parameter int NOUT  = 5,
  localparam int PW   = $clog2(NBANK),
  localparam int NQ   = NBANK * NOUT
) (
  input  logic             clk_in,
  input  logic             oe_n_rst,
  input  logic [NBANK-1:0] div_sel,
  input  logic [PW-1:0]    pol_code,
  output logic [NQ-1:0]    q_data,
  output logic [NQ-1:0]    q_oe
);

  logic [1:0] rel_sync;
  logic       run;
  logic       half;

  always_ff @(posedge clk_in or negedge oe_n_rst) begin
    if (!oe_n_rst) rel_sync <= 2'b00;
    else           rel_sync <= {rel_sync[0], 1'b1};
  end

  assign run = rel_sync[1];

  always_ff @(posedge clk_in or negedge oe_n_rst) begin
    if (!oe_n_rst)  half <= 1'b0;
    else if (!run)  half <= 1'b0;
    else            half <= ~half;
  end

  assign q_oe = {NQ{oe_n_rst}};

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    logic base, inv;
    assign inv  = (b <= int'(pol_code));
    assign base = div_sel[b] ? (run & clk_in) : half;
    assign q_data[b*NOUT +: NOUT] = {NOUT{base ^ inv}};
  end

endmodule

// File: rtl/bank_clk_div_chk.sv
module bank_clk_div_chk #(
  parameter int NBANK = 4,
  parameter int NOUT  = 5,
  localparam int PW   = $clog2(NBANK),
  localparam int NQ   = NBANK * NOUT
) (
  input logic             clk_in,
  input logic             oe_n_rst,
  input logic [NBANK-1:0] div_sel,
  input logic [PW-1:0]    pol_code,
  input logic [NQ-1:0]    q_data,
  input logic [NQ-1:0]    q_oe
);

  // R8
  oe_on_chk: assert property (@(posedge clk_in) disable iff (!oe_n_rst)
    oe_n_rst |-> (q_oe == {NQ{1'b1}}));

  // R5
  always @(negedge clk_in)
    if (oe_n_rst === 1'b0) oe_off_chk: assert (q_oe == '0);

  for (genvar b = 0; b < NBANK; b++) begin : g_b
    // R1
    bank_uniform_chk: assert property (@(posedge clk_in) disable iff (!oe_n_rst)
      q_data[b*NOUT +: NOUT] == {NOUT{q_data[b*NOUT]}});

    if (b > 0) begin : g_pair
      // R4
      polarity_step_chk: assert property (@(posedge clk_in) disable iff (!oe_n_rst)
        (div_sel[b] == div_sel[b-1] && int'(pol_code) == b-1)
          |-> (q_data[b*NOUT] != q_data[(b-1)*NOUT]));

      // R7
      half_phase_chk: assert property (@(posedge clk_in) disable iff (!oe_n_rst)
        (!div_sel[0] && !div_sel[b])
          |-> ((q_data[b*NOUT] ^ (b <= int'(pol_code))) == ~q_data[0]));
    end
  end

endmodule

bind bank_clk_div bank_clk_div_chk #(.NBANK(NBANK), .NOUT(NOUT)) chk_i (.*);

// File: tb/bank_clk_div_tb_top.sv
module bank_clk_div_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NBANK = 4;
  localparam int NOUT  = 5;
  localparam int NQ    = NBANK * NOUT;

  logic             clk_in = 1'b0;
  logic             oe_n_rst = 1'b0;
  logic [NBANK-1:0] div_sel = '0;
  logic [1:0]       pol_code = '0;
  logic [NQ-1:0]    q_data, q_oe;

  int n_checks = 0;
  int n_errors = 0;

  bank_clk_div #(.NBANK(NBANK), .NOUT(NOUT)) dut_i (
    .clk_in(clk_in), .oe_n_rst(oe_n_rst), .div_sel(div_sel),
    .pol_code(pol_code), .q_data(q_data), .q_oe(q_oe));

  always #(CLK_PERIOD/2) clk_in = ~clk_in;

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_errors++;
      $display("FAIL %s sel=%b pol=%0d got=%h exp=%h", tag, div_sel, pol_code, got, exp);
    end
  endtask

  function automatic logic [NQ-1:0] expect_vec(input int k, input logic clk_lvl);
    logic [NQ-1:0] v;
    for (int b = 0; b < NBANK; b++) begin
      logic run_e, half_e, base_e, inv_e;
      run_e  = (k >= 2);
      half_e = run_e ? logic'((k - 2) & 1) : 1'b0;
      base_e = div_sel[b] ? (run_e & clk_lvl) : half_e;
      inv_e  = (b <= int'(pol_code));
      v[b*NOUT +: NOUT] = {NOUT{base_e ^ inv_e}};
    end
    return v;
  endfunction

  task automatic check_sample(input int k, input logic clk_lvl);
    logic [NQ-1:0] e;
    e = expect_vec(k, clk_lvl);
    for (int b = 0; b < NBANK; b++) begin
      string t;
      t = (k < 2) ? "R6" : (div_sel[b] ? "R3" : "R2");
      check(t, 32'(q_data[b*NOUT +: NOUT]), 32'(e[b*NOUT +: NOUT]));
    end
    check("R8", 32'(q_oe), 32'({NQ{1'b1}}));
  endtask

  task automatic check_phase();
    logic ref_v;
    logic have;
    have = 1'b0;
    ref_v = 1'b0;
    for (int b = 0; b < NBANK; b++) begin
      if (!div_sel[b]) begin
        logic v;
        v = q_data[b*NOUT] ^ (b <= int'(pol_code));
        if (!have) begin ref_v = v; have = 1'b1; end
        else check("R7", 32'(v), 32'(ref_v));
      end
    end
  endtask

  initial begin : watchdog
    #(CLK_PERIOD * 200000);
    n_errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

  initial begin : stim
    logic [NQ-1:0] rest;
    #(CLK_PERIOD/4);
    check("R5", 32'(q_oe), 32'h0);
    for (int p = 0; p < 4; p++) begin
      for (int s = 0; s < 16; s++) begin
        @(negedge clk_in);
        oe_n_rst = 1'b0;
        div_sel  = s[NBANK-1:0];
        pol_code = p[1:0];
        @(posedge clk_in);
        #(CLK_PERIOD/4);
        rest = expect_vec(0, 1'b1);
        check("R5", 32'(q_oe), 32'h0);
        check("R4 R6", 32'(q_data), 32'(rest));
        for (int b = 0; b < NBANK; b++)
          check("R1", 32'(q_data[b*NOUT +: NOUT]), 32'({NOUT{q_data[b*NOUT]}}));
        @(negedge clk_in);
        #1;
        oe_n_rst = 1'b1;
        #1;
        check("R8", 32'(q_oe), 32'({NQ{1'b1}}));
        check("R6", 32'(q_data), 32'(rest));
        for (int k = 1; k <= 6; k++) begin
          @(posedge clk_in);
          #(CLK_PERIOD/4);
          check_sample(k, 1'b1);
          check_phase();
          if (k == 6) begin
            oe_n_rst = 1'b0;
            #1;
            check("R9", 32'(q_data), 32'(rest));
            check("R5", 32'(q_oe), 32'h0);
          end else begin
            #(CLK_PERIOD/2);
            check_sample(k, 1'b0);
          end
        end
      end
    end
    #(CLK_PERIOD);
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end
endmodule